// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a 32-bit periodic timer placed on a simple word-addressed register bus. Software programs a start value, a compare value and a clock divider. Once enabled, the counter steps downward by one on each divided tick. When the counter reaches zero, it either restarts from the start value or rolls over to all ones and keeps counting. Each tick that lands the counter on the compare value sets a sticky event flag. That flag can drive an interrupt line and can also set, clear or flip an output pin.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational function of the address. Every access completes in that one cycle, so the bus has no back-pressure and no handshake. The interrupt and the pin are plain level outputs.

Top module: `dcmp_timer`

## Requirements
- R1: After hardware reset, all five registers read zero and both `irq` and `cmp_pin` are low.
- R2: Word offsets are as follows: control 0x00, status 0x04, start value 0x08, compare 0x0C and count 0x10. Control stores bits 25:21 and 19:0 and reads zero in bits 31:26 and bit 20. Writes to the count offset are ignored.
- R3: Control bits are laid out as follows. Bit 0 runs the timer and bits 15:4 hold the divider D. While running, the count drops by one every D+1 clocks, and the first step comes D+1 clocks after the edge that starts the timer. While stopped, the count holds.
- R4: Bit 3 is the restart choice. A tick at count zero loads the start value when bit 3 is 1 and loads 0xFFFFFFFF when bit 3 is 0.
- R5: Bit 1 is the start mode. A write that moves bit 0 from 0 to 1 with bit 1 set copies the start value into the count and clears the divider. With bit 1 clear, counting resumes from the held count and divider phase.
- R6: With control bit 17 set, a write to the start value also writes the count at the same edge. With bit 17 clear, the count is untouched.
- R7: Status bit 0 is set at the edge where a tick makes the count equal the compare value. Writing 1 to it clears it, and writing 0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R8: `irq` equals status bit 0 ANDed with control bit 2.
- R9: Control bits 23:22 set the pin action on each compare event: 00 holds `cmp_pin` low, 01 flips it, 10 drives it low and 11 drives it high. The pin keeps its level between events.
- R10: A control write with bit 16 set clears every register, the pin and the divider. The next read shows control equal to 0x00010000. Bit 16 clears itself one clock later, and any bus write in that cycle is ignored.
- R11: With a start value of 0xFFFFFFFF, no restart and a divider of 0, the count runs down through the full 32-bit range from 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt level |
| cmp_pin | output | 1 | Output-compare pin |

## Verification
A wrong divider phase or a wrong restart choice shows up on the count read-back within one tick period. It then throws the `irq` edge and the parity of the pin off by whole periods. A flag or pin register that takes a compare event at the wrong edge becomes visible on `irq` or `cmp_pin` in the very next cycle. A self-reset bit that lingers shows up on the following control read, and the write it swallows shows up on the next register read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_STAT = 32'h04;
  localparam int unsigned OFF_LOAD = 32'h08;
  localparam int unsigned OFF_CMP  = 32'h0C;
  localparam int unsigned OFF_CNT  = 32'h10;

  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int B_CIE    = 2;
  localparam int B_RLD    = 3;
  localparam int B_PSC_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_OM_LO  = 22;

  localparam logic [31:0] CTRL_WMASK = 32'h03EF_FFFF;

  typedef enum logic [1:0] {
    PIN_OFF  = 2'b00,
    PIN_FLIP = 2'b01,
    PIN_LOW  = 2'b10,
    PIN_HIGH = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] pc_q;
  logic          wrap;

  assign wrap = (pc_q >= div);
  assign tick = run & ~clr & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (clr)    pc_q <= '0;
    else if (run)    pc_q <= wrap ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ovw,
  input  logic [DW-1:0] ovw_val,
  input  logic          start,
  input  logic [DW-1:0] ld_val,
  input  logic          tick,
  input  logic          rld,
  input  logic [DW-1:0] cmp_val,
  output logic [DW-1:0] cnt,
  output logic          hit
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] nxt;

  always_comb begin
    if (cnt_q == '0) nxt = rld ? ld_val : '1;
    else             nxt = cnt_q - 1'b1;
  end

  assign hit = tick & ~clr & ~ovw & ~start & (nxt == cmp_val);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ovw)    cnt_q <= ovw_val;
    else if (start)  cnt_q <= ld_val;
    else if (tick)   cnt_q <= nxt;
  end
endmodule

// File: rtl/tmr_pinact.sv
module tmr_pinact
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      hit,
  input  pin_mode_e mode,
  output logic      pin
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (clr)    pin_q <= 1'b0;
    else if (hit) begin
      case (mode)
        PIN_FLIP: pin_q <= ~pin_q;
        PIN_LOW:  pin_q <= 1'b0;
        PIN_HIGH: pin_q <= 1'b1;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign pin = (mode == PIN_OFF) ? 1'b0 : pin_q;
endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
  import tmr_pkg::*;
#(
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PSC_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          cmp_pin
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_LOAD = AW'(OFF_LOAD);
  localparam logic [AW-1:0] A_CMP  = AW'(OFF_CMP);
  localparam logic [AW-1:0] A_CNT  = AW'(OFF_CNT);

  logic [31:0]   ctrl_q;
  logic [DW-1:0] load_q;
  logic [DW-1:0] cmp_q;
  logic          flag_q;
  logic [DW-1:0] cnt_w;
  logic          tick, hit;

  logic wr_ok, wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic sw_rst, en_rise, start_ld, ovw_wr, running;

  assign wr_ok    = bus_we & ~ctrl_q[B_SWR];
  assign wr_ctrl  = wr_ok & (bus_addr == A_CTRL);
  assign wr_stat  = wr_ok & (bus_addr == A_STAT);
  assign wr_load  = wr_ok & (bus_addr == A_LOAD);
  assign wr_cmp   = wr_ok & (bus_addr == A_CMP);

  assign sw_rst   = wr_ctrl & bus_wdata[B_SWR];
  assign en_rise  = wr_ctrl & bus_wdata[B_EN] & ~ctrl_q[B_EN] & ~bus_wdata[B_SWR];
  assign start_ld = en_rise & bus_wdata[B_ENMOD];
  assign ovw_wr   = wr_load & ctrl_q[B_OVW];
  assign running  = ctrl_q[B_EN] & ~ctrl_q[B_SWR];

  // control register with self-clearing reset bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl_q <= '0;
    else if (sw_rst)         ctrl_q <= 32'h1 << B_SWR;
    else if (ctrl_q[B_SWR])  ctrl_q <= '0;
    else if (wr_ctrl)        ctrl_q <= bus_wdata & CTRL_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        load_q <= '0;
    else if (sw_rst)   load_q <= '0;
    else if (wr_load)  load_q <= bus_wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (sw_rst)   cmp_q <= '0;
    else if (wr_cmp)   cmp_q <= bus_wdata[DW-1:0];
  end

  // sticky compare flag: set beats write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (sw_rst)                  flag_q <= 1'b0;
    else if (hit)                     flag_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
  end

  tmr_prescaler #(.PW(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .clr   (sw_rst | start_ld | ovw_wr),
    .div   (ctrl_q[B_PSC_LO +: PSC_W]),
    .tick  (tick)
  );

  tmr_downcnt #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sw_rst),
    .ovw     (ovw_wr),
    .ovw_val (bus_wdata[DW-1:0]),
    .start   (start_ld),
    .ld_val  (load_q),
    .tick    (tick),
    .rld     (ctrl_q[B_RLD]),
    .cmp_val (cmp_q),
    .cnt     (cnt_w),
    .hit     (hit)
  );

  tmr_pinact u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sw_rst),
    .hit   (hit),
    .mode  (pin_mode_e'(ctrl_q[B_OM_LO +: 2])),
    .pin   (cmp_pin)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {31'b0, flag_q};
      A_LOAD:  bus_rdata = 32'(load_q);
      A_CMP:   bus_rdata = 32'(cmp_q);
      A_CNT:   bus_rdata = 32'(cnt_w);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ctrl_q[B_CIE];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [31:0]   ctrl,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] cmp,
  input logic          flag,
  input logic          irq,
  input logic          pin
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[16] && !bus_we) |=> $stable(cnt));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[16] && !bus_we && cnt != '0)
      |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[3] && !ctrl[16] && !bus_we && cnt == '0)
      |=> (cnt == '0 || cnt == '1));

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == cmp));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[23:22] == 2'b00) |-> !pin);

  assert_swr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[16] |=> (ctrl == '0));
endmodule

bind dcmp_timer tmr_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bus_we (bus_we),
  .ctrl   (ctrl_q),
  .cnt    (cnt_w),
  .cmp    (cmp_q),
  .flag   (flag_q),
  .irq    (irq),
  .pin    (cmp_pin)
);

// File: tb/test_dcmp_timer.sv
module test_dcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, cmp_pin;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  localparam logic [4:0] RC = 5'h00, RS = 5'h04, RL = 5'h08, RM = 5'h0C, RN = 5'h10;

  dcmp_timer i_dcmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmp_pin(cmp_pin)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic swr();
    wr(RC, 32'h0001_0000);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] ev(input int n, input longint ld, input bit r);
    if (r) return 32'(ld - (longint'(n) % (ld + 1)));
    if (longint'(n) <= ld) return 32'(ld - n);
    return 32'(64'hFFFF_FFFF - (longint'(n) - ld - 1));
  endfunction

  function automatic int hits(input int n, input longint ld, input bit r, input logic [31:0] c);
    int h = 0;
    for (int j = 1; j <= n; j++) if (ev(j, ld, r) == c) h++;
    return h;
  endfunction

  logic [31:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(RC, d); chk("R1 ctrl", d, 0);
    rd(RS, d); chk("R1 stat", d, 0);
    rd(RL, d); chk("R1 load", d, 0);
    rd(RM, d); chk("R1 cmp", d, 0);
    rd(RN, d); chk("R1 cnt", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin", {31'b0, cmp_pin}, 0);

    // R2 control field storage
    wr(RC, 32'hFFFE_FFFF);
    rd(RC, d); chk("R2 ctrl mask", d, 32'h03EE_FFFF);
    swr();

    // Sweep: R3 R4 R7 R8 R9 (toggle)
    for (int p = 0; p < 3; p++)
      for (int ld = 0; ld < 5; ld++)
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 3; c++) begin
            swr();
            wr(RL, ld);
            wr(RM, c);
            wr(RC, 32'h7 | (32'(r) << 3) | (32'(p) << 4) | (32'h1 << 22));
            for (int k = 0; k < 18; k++) begin
              int n, h;
              n = k / (p + 1);
              h = hits(n, ld, r[0], c);
              rd(RN, d);
              chk("R3 R4 count", d, ev(n, ld, r[0]));
              chk("R7 R8 irq", {31'b0, irq}, (h > 0) ? 1 : 0);
              chk("R9 toggle pin", {31'b0, cmp_pin}, 32'(h % 2));
              @(negedge clk);
            end
          end

    // R5 resume versus reload
    swr();
    wr(RL, 10);
    wr(RC, 32'hB);
    idle(3);
    rd(RN, d); chk("R5 run", d, 7);
    wr(RC, 32'h8);
    rd(RN, d); chk("R3 stop", d, 6);
    idle(3);
    rd(RN, d); chk("R3 hold", d, 6);
    wr(RC, 32'h1);
    rd(RN, d); chk("R5 resume k0", d, 6);
    idle(2);
    rd(RN, d); chk("R5 resume k2", d, 4);
    wr(RC, 32'h0);
    wr(RC, 32'h3);
    rd(RN, d); chk("R5 reload", d, 10);

    // R3 large divider
    swr();
    wr(RL, 1000);
    wr(RC, 32'h3 | (32'd4095 << 4));
    idle(4095);
    rd(RN, d); chk("R3 div edge-1", d, 1000);
    idle(1);
    rd(RN, d); chk("R3 div edge", d, 999);

    // R11 full range
    swr();
    wr(RL, 32'hFFFF_FFFF);
    wr(RC, 32'h3);
    rd(RN, d); chk("R11 start", d, 32'hFFFF_FFFF);
    idle(5);
    rd(RN, d); chk("R11 run", d, 32'hFFFF_FFFA);

    // R7 R8 write-one-to-clear and gating
    swr();
    wr(RL, 3); wr(RM, 1);
    wr(RC, 32'hF);
    idle(2);
    wr(RC, 32'hC);
    rd(RS, d); chk("R7 set", d, 1);
    chk("R8 irq on", {31'b0, irq}, 1);
    wr(RS, 0);
    rd(RS, d); chk("R7 write0", d, 1);
    wr(RC, 32'h8);
    chk("R8 irq gated", {31'b0, irq}, 0);
    rd(RS, d); chk("R8 flag kept", d, 1);
    wr(RS, 1);
    rd(RS, d); chk("R7 clear", d, 0);

    // R7 set wins over clear
    swr();
    wr(RL, 3); wr(RM, 2);
    wr(RC, 32'hB);
    wr(RS, 1);
    rd(RS, d); chk("R7 set wins", d, 1);

    // R9 set/clear/off modes
    swr();
    wr(RL, 3); wr(RM, 1);
    wr(RC, 32'h00C0_000B);
    idle(2);
    chk("R9 set", {31'b0, cmp_pin}, 1);
    wr(RC, 32'h0080_0008);
    chk("R9 held", {31'b0, cmp_pin}, 1);
    wr(RC, 32'h0080_000B);
    idle(2);
    chk("R9 clear", {31'b0, cmp_pin}, 0);
    wr(RC, 32'h00C0_0008);
    wr(RC, 32'h00C0_000B);
    idle(2);
    chk("R9 set again", {31'b0, cmp_pin}, 1);
    wr(RC, 32'h0000_0008);
    chk("R9 off", {31'b0, cmp_pin}, 0);

    // R6 overwrite, R2 read-only count
    swr();
    wr(RC, 32'h0002_0000);
    wr(RL, 32'h55);
    rd(RN, d); chk("R6 overwrite", d, 32'h55);
    wr(RN, 32'h1234);
    rd(RN, d); chk("R2 count ro", d, 32'h55);
    wr(RC, 32'h0);
    wr(RL, 32'h77);
    rd(RN, d); chk("R6 no overwrite", d, 32'h55);
    rd(RL, d); chk("R6 load", d, 32'h77);

    // R10 software reset
    wr(RM, 32'hCD);
    wr(RC, 32'h0001_0000);
    rd(RC, d); chk("R10 bit visible", d, 32'h0001_0000);
    wr(RL, 32'h99);
    rd(RC, d); chk("R10 self clear", d, 0);
    rd(RL, d); chk("R10 load cleared, write ignored", d, 0);
    rd(RM, d); chk("R10 cmp", d, 0);
    rd(RN, d); chk("R10 cnt", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule